// File: doc/BRIEF.md
# Matrix-Configured Mesh Port Switch

This block is the routing shell around a single processing element in a mesh of such elements. Each of its four sides (north, east, south, west) has its own number of incoming and outgoing data ports. The enclosed element adds further sources, which are its result ports, and further destinations, which are its operand ports. A connection matrix, fixed when the design is elaborated, lists which sources may reach each destination.

For every destination, the block counts the sources its matrix column permits and builds only what that count needs. With no permitted source, the destination is tied to zero. With one, it is a plain wire. With two or more, it gets a multiplexer whose select is held in a small register. Software or a controller writes that register through a narrow configuration port, giving the destination index and a select value. Data routing is purely combinational, and only the select registers are clocked.

Top module: `mesh_port_switch`

## Requirements
- R1: A destination whose matrix column has no 1 always outputs zero.
- R2: A destination with exactly one permitted source always equals that source, whatever is written on the configuration port.
- R3: A destination with two or more permitted sources outputs the source whose rank among its permitted sources equals its select value. Rank 0 is the permitted source with the lowest source index, and the rest follow in ascending index order.
- R4: While `rst_n` is low, and after it is released with no writes, every select is 0, so each multiplexed destination carries its lowest-indexed permitted source.
- R5: A write with `cfg_we` high, `cfg_dest` set to a multiplexed destination and `cfg_sel` below that destination's driver count changes the routing at the next rising clock edge and not before.
- R6: A write whose `cfg_sel` is equal to or greater than the addressed destination's driver count leaves that destination's select unchanged.
- R7: A write changes only the destination it addresses. Writes to non-multiplexed destinations, or to indices at or above the destination count, change nothing.
- R8: Source index order is north inputs, then east, south and west inputs, then element results. Destination index order is north outputs, then east, south and west outputs, then element operands. Within each group, port p occupies bits [p*W +: W]. Matrix bit s*NDST+d permits source s to drive destination d.
- R9: A change on any source appears on the destinations routed from it in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select registers |
| rst_n | input | 1 | Synchronous active-low reset |
| north_i | input | IN_N*W | Data arriving on the north side |
| east_i | input | IN_E*W | Data arriving on the east side |
| south_i | input | IN_S*W | Data arriving on the south side |
| west_i | input | IN_W*W | Data arriving on the west side |
| pe_res_i | input | PE_RES*W | Result ports of the enclosed element |
| north_o | output | OUT_N*W | Data leaving on the north side |
| east_o | output | OUT_E*W | Data leaving on the east side |
| south_o | output | OUT_S*W | Data leaving on the south side |
| west_o | output | OUT_W*W | Data leaving on the west side |
| pe_opnd_o | output | PE_OPND*W | Operand ports of the enclosed element |
| cfg_we | input | 1 | Select write strobe |
| cfg_dest | input | AW | Destination index of the write |
| cfg_sel | input | SEL_W | New select value (rank of the chosen source) |

## Verification
The assertions treat `cfg_dest` and `cfg_sel` as arbitrary. They only expect every input to be known at each clock edge once reset has been released, and they judge each select register against what was written the cycle before. The stimulus always drives the configuration port with defined values. It deliberately includes destination indices past the last destination and select values up to the full field width, so that rejected writes occur often alongside accepted ones. Source data is random in every cycle and is held steady across each checked window.

// File: rtl/mps_pkg.sv
// Package for the mesh port switch.
// Holds the matrix size bound and the elaboration-time helpers that read
// a connection matrix. Bit s*ndst+d set means source s may drive dest d.
package mps_pkg;

    localparam int ADJ_MAX = 4096;

    // Default pattern: every fourth destination empty, one hard-wired,
    // the rest with several sources selected by index stride.
    function automatic logic [ADJ_MAX-1:0] default_adj(input int nsrc, input int ndst);
        logic [ADJ_MAX-1:0] m;
        m = '0;
        for (int d = 0; d < ndst; d++) begin
            for (int s = 0; s < nsrc; s++) begin
                if ((d % 4) == 1)
                    m[s*ndst+d] = (s == (d % nsrc));
                else if ((d % 4) != 0)
                    m[s*ndst+d] = (((s + d) % 3) == 0);
            end
        end
        return m;
    endfunction

    // Number of permitted sources of one destination.
    function automatic int drv_count(input logic [ADJ_MAX-1:0] m, input int nsrc,
                                     input int ndst, input int d);
        int n;
        n = 0;
        for (int s = 0; s < nsrc; s++)
            if (m[s*ndst+d]) n++;
        return n;
    endfunction

    // Lowest permitted source index of one destination (0 if none).
    function automatic int first_src(input logic [ADJ_MAX-1:0] m, input int nsrc,
                                     input int ndst, input int d);
        for (int s = nsrc - 1; s >= 0; s--)
            if (m[s*ndst+d]) first_src = s;
        if (drv_count(m, nsrc, ndst, d) == 0) first_src = 0;
    endfunction

    // Column of one destination as a source mask.
    function automatic logic [63:0] col_mask(input logic [ADJ_MAX-1:0] m, input int nsrc,
                                             input int ndst, input int d);
        logic [63:0] c;
        c = '0;
        for (int s = 0; s < nsrc; s++)
            c[s] = m[s*ndst+d];
        return c;
    endfunction

endpackage

// File: rtl/mps_sel_reg.sv
// Select register for one multiplexed destination.
// Accepts a write only when addressed and when the value is below the
// destination's driver count; otherwise holds. Synchronous active-low reset.
module mps_sel_reg #(
    parameter int SW    = 1,
    parameter int SEL_W = 5,
    parameter int AW    = 5,
    parameter int IDX   = 0,
    parameter int CNT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_dest,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic [SW-1:0]    sel_o
);
    localparam logic [AW-1:0]  MY_ADDR = AW'(IDX);
    localparam logic [SEL_W:0] LIMIT   = (SEL_W+1)'(CNT);

    logic accept;

    // Decide whether the current write targets this register with a legal value.
    always_comb accept = cfg_we && (cfg_dest == MY_ADDR) && ({1'b0, cfg_sel} < LIMIT);

    // Hold or update the select value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_o <= '0;
        else if (accept)
            sel_o <= cfg_sel[SW-1:0];
    end
endmodule

// File: rtl/mps_dest_mux.sv
// Ranked source multiplexer for one destination.
// Picks the permitted source whose rank among the set MASK bits equals sel.
// Assumes sel is below the number of set bits; otherwise outputs zero.
module mps_dest_mux #(
    parameter int               W    = 32,
    parameter int               NSRC = 20,
    parameter int               SW   = 1,
    parameter logic [NSRC-1:0]  MASK = '1
) (
    input  logic [NSRC*W-1:0] src_i,
    input  logic [SW-1:0]     sel_i,
    output logic [W-1:0]      dout_o
);
    // Walk permitted sources in index order and take the one at rank sel.
    always_comb begin
        int rank;
        rank   = 0;
        dout_o = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (MASK[s]) begin
                if (rank == int'(sel_i)) dout_o = src_i[s*W +: W];
                rank++;
            end
        end
    end
endmodule

// File: rtl/mesh_port_switch.sv
// Matrix-configured routing shell around one processing element.
// Sources: side inputs N,E,S,W then element results. Destinations: side
// outputs N,E,S,W then element operands. Each destination becomes a zero,
// a wire or a run-time selected multiplexer depending on its driver count.
module mesh_port_switch #(
    parameter int W       = 32,
    parameter int IN_N    = 4,
    parameter int IN_E    = 4,
    parameter int IN_S    = 4,
    parameter int IN_W    = 4,
    parameter int OUT_N   = 4,
    parameter int OUT_E   = 4,
    parameter int OUT_S   = 4,
    parameter int OUT_W   = 4,
    parameter int PE_RES  = 4,
    parameter int PE_OPND = 4,
    parameter logic [mps_pkg::ADJ_MAX-1:0] ADJ = mps_pkg::default_adj(
        IN_N + IN_E + IN_S + IN_W + PE_RES, OUT_N + OUT_E + OUT_S + OUT_W + PE_OPND),
    localparam int NSRC   = IN_N + IN_E + IN_S + IN_W + PE_RES,
    localparam int NDST   = OUT_N + OUT_E + OUT_S + OUT_W + PE_OPND,
    localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int AW     = (NDST > 1) ? $clog2(NDST) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IN_N*W-1:0]    north_i,
    input  logic [IN_E*W-1:0]    east_i,
    input  logic [IN_S*W-1:0]    south_i,
    input  logic [IN_W*W-1:0]    west_i,
    input  logic [PE_RES*W-1:0]  pe_res_i,
    output logic [OUT_N*W-1:0]   north_o,
    output logic [OUT_E*W-1:0]   east_o,
    output logic [OUT_S*W-1:0]   south_o,
    output logic [OUT_W*W-1:0]   west_o,
    output logic [PE_OPND*W-1:0] pe_opnd_o,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_dest,
    input  logic [SEL_W-1:0]     cfg_sel
);
    localparam int OFF_E = OUT_N;
    localparam int OFF_S = OFF_E + OUT_E;
    localparam int OFF_W = OFF_S + OUT_S;
    localparam int OFF_P = OFF_W + OUT_W;

    logic [NSRC*W-1:0]     src_bus;
    logic [NDST*W-1:0]     dst_bus;
    logic [NDST*SEL_W-1:0] sel_bus;

    // Gather all sources in index order, north lowest.
    assign src_bus = {pe_res_i, west_i, south_i, east_i, north_i};

    // Split destinations back onto the sides.
    assign north_o   = dst_bus[0       +: OUT_N*W];
    assign east_o    = dst_bus[OFF_E*W +: OUT_E*W];
    assign south_o   = dst_bus[OFF_S*W +: OUT_S*W];
    assign west_o    = dst_bus[OFF_W*W +: OUT_W*W];
    assign pe_opnd_o = dst_bus[OFF_P*W +: PE_OPND*W];

    for (genvar d = 0; d < NDST; d++) begin : g_dst
        localparam int CNT = mps_pkg::drv_count(ADJ, NSRC, NDST, d);
        if (CNT == 0) begin : g_empty
            assign dst_bus[d*W +: W]           = '0;
            assign sel_bus[d*SEL_W +: SEL_W]   = '0;
        end else if (CNT == 1) begin : g_wire
            localparam int SRC = mps_pkg::first_src(ADJ, NSRC, NDST, d);
            assign dst_bus[d*W +: W]           = src_bus[SRC*W +: W];
            assign sel_bus[d*SEL_W +: SEL_W]   = '0;
        end else begin : g_mux
            localparam int          SW  = $clog2(CNT);
            localparam logic [63:0] COL = mps_pkg::col_mask(ADJ, NSRC, NDST, d);
            logic [SW-1:0] sel_d;

            mps_sel_reg #(.SW(SW), .SEL_W(SEL_W), .AW(AW), .IDX(d), .CNT(CNT)) u_sel (
                .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dest(cfg_dest),
                .cfg_sel(cfg_sel), .sel_o(sel_d)
            );

            mps_dest_mux #(.W(W), .NSRC(NSRC), .SW(SW), .MASK(COL[NSRC-1:0])) u_mux (
                .src_i(src_bus), .sel_i(sel_d), .dout_o(dst_bus[d*W +: W])
            );

            assign sel_bus[d*SEL_W +: SEL_W] = SEL_W'(sel_d);
        end
    end
endmodule

// File: rtl/mps_checker.sv
// Property checker for the mesh port switch, bound to every instance.
// Observes the gathered source and destination buses and the select values.
module mps_checker #(
    parameter int W     = 32,
    parameter int NSRC  = 20,
    parameter int NDST  = 20,
    parameter int SEL_W = 5,
    parameter int AW    = 5,
    parameter logic [mps_pkg::ADJ_MAX-1:0] ADJ = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [AW-1:0]         cfg_dest,
    input logic [SEL_W-1:0]      cfg_sel,
    input logic [NSRC*W-1:0]     src_flat,
    input logic [NDST*W-1:0]     dst_flat,
    input logic [NDST*SEL_W-1:0] sel_flat
);
    for (genvar d = 0; d < NDST; d++) begin : g_chk
        localparam int CNT = mps_pkg::drv_count(ADJ, NSRC, NDST, d);
        localparam int SRC = mps_pkg::first_src(ADJ, NSRC, NDST, d);
        localparam logic [AW-1:0]  ME  = AW'(d);
        localparam logic [SEL_W:0] LIM = (SEL_W+1)'(CNT);
        if (CNT == 0) begin : g_e
            AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                dst_flat[d*W +: W] == '0); // R1
        end else if (CNT == 1) begin : g_w
            AST_WIRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                dst_flat[d*W +: W] == src_flat[SRC*W +: W]); // R2
        end else begin : g_m
            AST_SEL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
                {1'b0, sel_flat[d*SEL_W +: SEL_W]} < LIM); // R3
            AST_RESET_LOWEST: assert property (@(posedge clk)
                !rst_n |=> sel_flat[d*SEL_W +: SEL_W] == '0); // R4
            AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_dest == ME && {1'b0, cfg_sel} < LIM)
                |=> sel_flat[d*SEL_W +: SEL_W] == $past(cfg_sel)); // R5
            AST_OOR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_dest == ME && {1'b0, cfg_sel} >= LIM)
                |=> $stable(sel_flat[d*SEL_W +: SEL_W])); // R6
            AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_we || cfg_dest != ME) |=> $stable(sel_flat[d*SEL_W +: SEL_W])); // R7
        end
    end
endmodule

bind mesh_port_switch mps_checker #(
    .W(W), .NSRC(NSRC), .NDST(NDST), .SEL_W(SEL_W), .AW(AW), .ADJ(ADJ)
) u_mps_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dest(cfg_dest), .cfg_sel(cfg_sel),
    .src_flat(src_bus), .dst_flat(dst_bus), .sel_flat(sel_bus)
);

// File: tb/mesh_port_switch_bench.sv
`timescale 1ns/1ps
// Bench for the mesh port switch: random data and configuration writes
// plus directed reset, legal and illegal select cases, against a model.
module mesh_port_switch_bench;
    localparam int W     = 32;
    localparam int NS    = 4;
    localparam int NSRC  = 5 * NS;
    localparam int NDST  = 5 * NS;
    localparam int SEL_W = 5;
    localparam int AW    = 5;
    localparam logic [mps_pkg::ADJ_MAX-1:0] ADJ = mps_pkg::default_adj(NSRC, NDST);

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_we;
    logic [AW-1:0]    cfg_dest;
    logic [SEL_W-1:0] cfg_sel;
    logic [NSRC*W-1:0] src_flat;
    logic [NDST*W-1:0] dst_flat;
    logic [NS*W-1:0] n_o, e_o, s_o, w_o, p_o;
    int msel [NDST];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mesh_port_switch u_mesh_port_switch (
        .clk(clk), .rst_n(rst_n),
        .north_i(src_flat[0 +: NS*W]), .east_i(src_flat[NS*W +: NS*W]),
        .south_i(src_flat[2*NS*W +: NS*W]), .west_i(src_flat[3*NS*W +: NS*W]),
        .pe_res_i(src_flat[4*NS*W +: NS*W]),
        .north_o(n_o), .east_o(e_o), .south_o(s_o), .west_o(w_o), .pe_opnd_o(p_o),
        .cfg_we(cfg_we), .cfg_dest(cfg_dest), .cfg_sel(cfg_sel)
    );

    assign dst_flat = {p_o, w_o, s_o, e_o, n_o};

    function automatic int cnt_of(int d);
        int n = 0;
        for (int s = 0; s < NSRC; s++) if (ADJ[s*NDST+d]) n++;
        return n;
    endfunction

    function automatic logic [W-1:0] model_out(int d);
        int r = 0;
        logic [W-1:0] v = '0;
        for (int s = 0; s < NSRC; s++)
            if (ADJ[s*NDST+d]) begin
                if (r == msel[d]) v = src_flat[s*W +: W];
                r++;
            end
        return v;
    endfunction

    task automatic randomize_src();
        for (int s = 0; s < NSRC; s++) src_flat[s*W +: W] = $urandom;
    endtask

    task automatic check_all(string mux_tag);
        for (int d = 0; d < NDST; d++) begin
            logic [W-1:0] exp_v = model_out(d);
            logic [W-1:0] act_v = dst_flat[d*W +: W];
            int c = cnt_of(d);
            string tag = (c == 0) ? "R1" : (c == 1) ? "R2 R8" : mux_tag;
            n_chk++;
            if (act_v !== exp_v) begin
                n_err++;
                $display("FAIL %s dest %0d: actual %h expected %h", tag, d, act_v, exp_v);
            end
        end
    endtask

    // One write cycle: check before the edge with old selects, after with new.
    task automatic step(bit we, int dest, int sel, string post_tag);
        @(negedge clk);
        cfg_we = we; cfg_dest = AW'(dest); cfg_sel = SEL_W'(sel);
        randomize_src();
        #1 check_all("R5 R9");
        @(posedge clk);
        #1;
        if (we && dest < NDST && cnt_of(dest) >= 2 && sel < cnt_of(dest)) msel[dest] = sel;
        check_all(post_tag);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_dest = '0; cfg_sel = '0;
        for (int d = 0; d < NDST; d++) msel[d] = 0;
        randomize_src();
        repeat (3) @(posedge clk);
        // Writes during reset must not land.
        @(negedge clk); cfg_we = 1'b1; cfg_dest = 5'd2; cfg_sel = 5'd3;
        @(negedge clk); cfg_we = 1'b0; rst_n = 1'b1;
        #1 check_all("R4");
        // R5: legal write to a multiplexed destination.
        step(1, 2, 3, "R5");
        // R6: select at and past the driver count of dest 2 (7 drivers).
        step(1, 2, 7, "R6");
        step(1, 2, 31, "R6");
        // R7: writes to empty, wired and out-of-range destinations.
        step(1, 0, 1, "R7");
        step(1, 1, 1, "R7");
        step(1, 25, 2, "R7");
        // R3: highest legal rank on dest 3.
        step(1, 3, 6, "R3");
        for (int i = 0; i < 300; i++)
            step(($urandom % 2) == 1, $urandom % 32, $urandom % 32, "R3 R6 R7");
        @(negedge clk); cfg_we = 1'b0;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule